// File: doc/BRIEF.md
# Thermometer-to-Binary Encoder with PRBS15 Output Scrambler

This block sits behind a bank of fifteen comparators. Every sample clock it takes their thermometer vector, reduces it to a 4-bit binary word and mixes each bit of that word with one pseudo-random bit. The result leaves the block through a register. The pseudo-random source is a 15-stage linear feedback shift register with feedback polynomial x^15 + x^14 + 1. A downstream receiver that runs the same sequence from the all-ones state can undo the mixing with a plain XOR.

Three controls shape the output. A generator enable stops the register and forces the shared bit to zero, which makes the block a transparent encoder. A data-keep select either outputs the scrambled word or replaces all four lanes with the raw pseudo-random bit. An asynchronous preset loads every register stage with one at once. Its release passes through a two-flop synchronizer, so the sequence restarts cleanly on a clock edge.

The pipeline has two register stages and runs on a single clock. The encoded word, the pseudo-random bit and the lane select are captured together in the first stage. The mixed word is captured in the second.

Top module: `therm_prbs_scrambler`

## Requirements
- R1: While `rst_n` is low, `word_o` is 0000. After reset the generator state is all ones, so its first fifteen output bits are 1.
- R2: The encoded value is the number of ones in `therm_i` (0 to 15, bit 3 the MSB). It is also correct for vectors with bubbles that are not clean thermometer codes.
- R3: An input sampled on one rising edge reaches `word_o` after the second rising edge. This applies to `therm_i`, `prbs_en_i` and `data_en_i`.
- R4: When enabled, the generator shifts one stage per clock. The new stage-1 bit is stage 15 XOR stage 14, and the bit used for mixing is stage 15. The state is never all zeros.
- R5: With the generator running freely, the stream of mixing bits repeats with a period of exactly 32,767 clocks.
- R6: While `prbs_en_i` is 0, the mixing bit is 0 and the generator state is frozen. With `data_en_i` at 1, `word_o` then equals the encoded value. When the generator is enabled again, the sequence resumes from the frozen state.
- R7: When `data_en_i` is 0, all four bits of `word_o` equal the mixing bit (1111 or 0000), whatever `therm_i` holds.
- R8: A high `preset_i` forces every generator stage to 1 at once, without waiting for a clock. After it goes low, the state stays all ones for two more rising edges and starts shifting on the third.
- R9: When `data_en_i` is 1, `word_o` is the encoded value with every bit XORed by the same mixing bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline; also presets the generator |
| therm_i | input | 15 | Comparator outputs, one bit per level |
| prbs_en_i | input | 1 | 1 runs the generator, 0 freezes it and zeroes the mixing bit |
| data_en_i | input | 1 | 1 outputs the mixed word, 0 outputs the mixing bit on all lanes |
| preset_i | input | 1 | Asynchronous active-high preset of the generator to all ones |
| word_o | output | 4 | Registered output word, bit 3 the MSB |

## Verification
The assertions assume that the controls and `therm_i` are synchronous to `clk`. They also assume that `preset_i` only changes away from the rising edge, so the immediate preset and the synchronized release each fall in a known cycle. The stimulus changes every input on the falling edge. It raises and drops the preset only there, and it keeps `prbs_en_i` steady over the long free-running window used for the period measurement. Frozen and resumed stretches, preset pulses in mid-sequence and random bubbly vectors are applied in separate phases, so each output word can be traced to one mode.

// File: rtl/therm_prbs_pkg.sv
package therm_prbs_pkg;
    localparam int unsigned DEF_LEVELS   = 15;
    localparam int unsigned DEF_LFSR_LEN = 15;
    localparam int unsigned DEF_TAP_HI   = 15;
    localparam int unsigned DEF_TAP_LO   = 14;
    localparam int unsigned DEF_SYNC     = 2;

    function automatic int unsigned code_width(input int unsigned levels);
        return $clog2(levels + 1);
    endfunction
endpackage

// File: rtl/therm_popcount.sv
module therm_popcount #(
    parameter int unsigned LEVELS = 15,
    parameter int unsigned CODE_W = 4
) (
    input  logic [LEVELS-1:0] therm_i,
    output logic [CODE_W-1:0] code_o
);
    // Counting ones tolerates bubbles that a single-transition search would misread.
    always_comb begin
        code_o = '0;
        for (int i = 0; i < int'(LEVELS); i++) begin
            code_o = code_o + CODE_W'(therm_i[i]);
        end
    end
endmodule

// File: rtl/prbs_lfsr.sv
module prbs_lfsr #(
    parameter int unsigned LEN         = 15,
    parameter int unsigned TAP_HI      = 15,
    parameter int unsigned TAP_LO      = 14,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           preset_i,
    input  logic           step_i,
    output logic [LEN-1:0] state_o,
    output logic           bit_o
);
    typedef struct packed {
        logic [LEN-1:0]         state;
        logic [SYNC_STAGES-1:0] sync;
    } gen_t;

    gen_t gen_d, gen_q;
    logic preset_async;
    logic hold;

    assign preset_async = preset_i | ~rst_n;
    assign hold         = gen_q.sync[SYNC_STAGES-1];

    always_comb begin
        gen_d      = gen_q;
        gen_d.sync = {gen_q.sync[SYNC_STAGES-2:0], 1'b0};
        if (hold) begin
            gen_d.state = '1;
        end else if (step_i) begin
            gen_d.state = {gen_q.state[LEN-2:0],
                           gen_q.state[TAP_HI-1] ^ gen_q.state[TAP_LO-1]};
        end
    end

    always_ff @(posedge clk or posedge preset_async) begin
        if (preset_async) begin
            gen_q <= '1;
        end else begin
            gen_q <= gen_d;
        end
    end

    assign state_o = gen_q.state;
    assign bit_o   = gen_q.state[LEN-1];
endmodule

// File: rtl/therm_prbs_scrambler.sv
module therm_prbs_scrambler
    import therm_prbs_pkg::*;
#(
    parameter int unsigned LEVELS      = DEF_LEVELS,
    parameter int unsigned LFSR_LEN    = DEF_LFSR_LEN,
    parameter int unsigned TAP_HI      = DEF_TAP_HI,
    parameter int unsigned TAP_LO      = DEF_TAP_LO,
    parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEVELS-1:0] therm_i,
    input  logic              prbs_en_i,
    input  logic              data_en_i,
    input  logic              preset_i,
    output logic [3:0]        word_o
);
    localparam int unsigned CODE_W = code_width(LEVELS);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              mix_bit;
        logic              keep_data;
        logic [CODE_W-1:0] word;
    } pipe_t;

    pipe_t             pipe_d, pipe_q;
    logic [CODE_W-1:0] code_w;
    logic [CODE_W-1:0] lane_w;
    logic [LFSR_LEN-1:0] lfsr_state;
    logic              lfsr_bit;

    therm_popcount #(.LEVELS(LEVELS), .CODE_W(CODE_W)) u_enc (
        .therm_i (therm_i),
        .code_o  (code_w)
    );

    prbs_lfsr #(
        .LEN(LFSR_LEN), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO), .SYNC_STAGES(SYNC_STAGES)
    ) u_lfsr (
        .clk      (clk),
        .rst_n    (rst_n),
        .preset_i (preset_i),
        .step_i   (prbs_en_i),
        .state_o  (lfsr_state),
        .bit_o    (lfsr_bit)
    );

    for (genvar g = 0; g < int'(CODE_W); g++) begin : g_lane
        assign lane_w[g] = pipe_q.keep_data ? (pipe_q.code[g] ^ pipe_q.mix_bit)
                                            : pipe_q.mix_bit;
    end

    always_comb begin
        pipe_d           = pipe_q;
        pipe_d.code      = code_w;
        pipe_d.mix_bit   = prbs_en_i & lfsr_bit;
        pipe_d.keep_data = data_en_i;
        pipe_d.word      = lane_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign word_o = 4'(pipe_q.word);
endmodule

// File: rtl/therm_prbs_checker.sv
module therm_prbs_checker #(
    parameter int unsigned LEVELS   = 15,
    parameter int unsigned LFSR_LEN = 15
) (
    input logic                clk,
    input logic                rst_n,
    input logic [LEVELS-1:0]   therm_i,
    input logic                prbs_en_i,
    input logic                data_en_i,
    input logic                preset_i,
    input logic [3:0]          word_o,
    input logic [LFSR_LEN-1:0] lfsr_state
);
    logic [1:0] age_q;
    logic       ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end
    assign ready = (age_q == 2'd3);

    always_comb begin
        if (!rst_n) AST_RESET_ZERO: assert (word_o == 4'd0); // R1
    end

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_state != '0); // R4

    AST_PRESET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        preset_i |-> lfsr_state == '1); // R8

    AST_FROZEN_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!prbs_en_i && !preset_i) |=> ($stable(lfsr_state) || preset_i)); // R6

    AST_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !$past(prbs_en_i, 2) && $past(data_en_i, 2))
        |-> word_o == 4'($countones($past(therm_i, 2)))); // R2

    AST_SILENT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !$past(prbs_en_i, 2) && !$past(data_en_i, 2)) |-> word_o == 4'd0); // R7

    AST_LANES_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !$past(data_en_i, 2)) |-> (word_o == 4'hF || word_o == 4'h0)); // R7

    AST_SHARED_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(data_en_i, 2))
        |-> ((word_o ^ 4'($countones($past(therm_i, 2)))) == 4'h0 ||
             (word_o ^ 4'($countones($past(therm_i, 2)))) == 4'hF)); // R9
endmodule

bind therm_prbs_scrambler therm_prbs_checker #(
    .LEVELS(LEVELS), .LFSR_LEN(LFSR_LEN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .therm_i    (therm_i),
    .prbs_en_i  (prbs_en_i),
    .data_en_i  (data_en_i),
    .preset_i   (preset_i),
    .word_o     (word_o),
    .lfsr_state (lfsr_state)
);

// File: tb/therm_prbs_scrambler_bench.sv
module therm_prbs_scrambler_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PERIOD     = 32767;
    localparam int WIN        = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] therm_i = '0;
    logic        prbs_en_i = 1'b0;
    logic        data_en_i = 1'b1;
    logic        preset_i = 1'b0;
    logic [3:0]  word_o;

    int    checks = 0;
    int    fails  = 0;
    string tag    = "R1";
    bit    cmp_on = 1'b0;

    // reference model state
    logic [14:0] m_s = '1;
    bit          m_q0 = 1'b1, m_q1 = 1'b1;
    int          m_code = 0;
    bit          m_bit = 1'b0, m_keep = 1'b0;
    logic [3:0]  m_out = '0;

    therm_prbs_scrambler u_therm_prbs_scrambler (
        .clk(clk), .rst_n(rst_n), .therm_i(therm_i), .prbs_en_i(prbs_en_i),
        .data_en_i(data_en_i), .preset_i(preset_i), .word_o(word_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int ones(input logic [14:0] v);
        int n = 0;
        for (int i = 0; i < 15; i++) if (v[i]) n++;
        return n;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s = '1; m_q0 = 1; m_q1 = 1;
            m_code = 0; m_bit = 0; m_keep = 0; m_out = '0;
        end else begin
            bit       nb;
            bit       hold;
            hold = m_q1;
            if (preset_i) m_s = '1;
            nb = prbs_en_i ? m_s[14] : 1'b0;
            m_out = m_keep ? (4'(m_code) ^ {4{m_bit}}) : {4{m_bit}};
            if (preset_i || hold) m_s = '1;
            else if (prbs_en_i) m_s = {m_s[13:0], m_s[14] ^ m_s[13]};
            m_q1 = preset_i ? 1'b1 : m_q0;
            m_q0 = preset_i;
            m_code = ones(therm_i); m_bit = nb; m_keep = data_en_i;
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            checks++;
            if (word_o !== m_out) begin
                fails++;
                $display("FAIL %s word_o=%h expected=%h", tag, word_o, m_out);
            end
        end
    end

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s word_o=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input int n, input bit rnd, input logic [14:0] v);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            therm_i = rnd ? 15'($urandom) : v;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        logic [WIN-1:0] first;
        repeat (3) @(negedge clk);
        check("R1", word_o, 4'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", word_o, 4'h0);
        cmp_on = 1'b1;

        // R2: clean codes and bubbles, generator off
        tag = "R2";
        for (int k = 0; k <= 15; k++) run(1, 0, 15'((32'd1 << k) - 1));
        run(60, 1, '0);
        run(1, 0, 15'h5555);

        // R3: explicit latency
        tag = "R3";
        run(3, 0, 15'h0000);
        @(negedge clk); therm_i = 15'h7FFF;
        @(negedge clk); check("R3", word_o, 4'h0);
        @(negedge clk); check("R3", word_o, 4'hF);

        // R1/R4/R5/R7: free-running raw sequence from all ones
        tag = "R7";
        prbs_en_i = 1'b1; data_en_i = 1'b0;
        run(20, 1, '0);
        first = '0;
        for (int i = 0; i < PERIOD + WIN; i++) begin
            @(negedge clk);
            therm_i = 15'($urandom);
            if (i < WIN) first[i] = word_o[0];
            if (i >= PERIOD) check("R5", {3'b0, word_o[0]}, {3'b0, first[i-PERIOD]});
        end

        // R9: scrambled data, descrambled by the model
        tag = "R9";
        data_en_i = 1'b1;
        run(200, 1, '0);

        // R6: freeze and resume
        tag = "R6";
        prbs_en_i = 1'b0;
        run(50, 1, '0);
        prbs_en_i = 1'b1;
        run(50, 1, '0);

        // R8: preset in mid-sequence, immediate set, delayed release
        tag = "R8";
        @(negedge clk); preset_i = 1'b1;
        run(4, 1, '0);
        @(negedge clk); preset_i = 1'b0;
        run(40, 1, '0);
        data_en_i = 1'b0;
        @(negedge clk); preset_i = 1'b1;
        run(2, 1, '0);
        @(negedge clk); preset_i = 1'b0;
        run(30, 1, '0);

        // R4: sequence after reset pulse starts with ones
        tag = "R4";
        cmp_on = 1'b0;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        cmp_on = 1'b1;
        run(60, 1, '0);

        cmp_on = 1'b0;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule